// File: doc/BRIEF.md
# Load/Store-Multiple Sequencer with Stack-Limit Guard

This block carries out one decoded load-multiple or store-multiple operation. The decoded operation gives a base register index, a 16-bit register-select mask, an address-mode flag (increment-after or decrement-before), a writeback flag and a load/store flag. The block reads the base register and works out the lowest address of the transfer block and the updated base. It then moves one 32-bit word for each selected register through a valid/ready memory port. Registers go in ascending index order to consecutive word addresses. When writeback is requested, the block writes the updated base value back last.

When stack checking is enabled, the base index is the stack pointer and writeback is set, the lowest address of the block is compared with a stack-limit value before any memory traffic starts. A violation cancels the whole operation. No memory access is made and no register is written. A one-cycle fault pulse is raised and the operation then retires with a done pulse. The register file sits outside the block. The block reaches it through one combinational read port and one write port.

Top module: `ldstm_seq`

## Requirements
- R1: With N bits set in the register-select mask (bit i selects register i), the transfer spans 4*N bytes. Increment-after mode starts at the base value. Decrement-before mode starts at base minus 4*N.
- R2: Selected registers are transferred in ascending index order, one 32-bit word each, at consecutive word addresses from the lowest address. Stores send the register's value.
- R3: When writeback is set, the base register is finally written with base+4*N in increment mode, or base-4*N in decrement mode.
- R4: When writeback is clear and the base is not in a load list, no register write goes to the base index.
- R5: The stack-limit check applies only when checking is enabled, the base index equals the stack-pointer index (13) and writeback is set. In every other case, an address below the limit proceeds normally.
- R6: A violation is the lowest address being strictly below the limit. A lowest address equal to the limit is not a violation. On a violation, fault pulses for one cycle and no memory request or register write occurs.
- R7: An incrementing stack-pointer operation that starts below the limit faults, even when its final base would be at or above the limit.
- R8: When the base register is in a load list, its loaded word is held back. It is written only after all other loaded registers.
- R9: A memory request holds valid, address and direction steady until ready is seen.
- R10: An empty register-select mask makes no memory access and no register write, and still reports done.
- R11: done pulses for exactly one cycle per operation. A new operation is accepted only while the block is idle, and no memory request is active then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Decoded operation present |
| cmd_ready | output | 1 | Block idle, operation accepted on this cycle |
| cmd_base_idx | input | 4 | Base register index |
| cmd_reg_list | input | 16 | Register-select mask, bit i = register i |
| cmd_dec_before | input | 1 | 1 = decrement-before, 0 = increment-after |
| cmd_wback | input | 1 | Write updated base back |
| cmd_load | input | 1 | 1 = load, 0 = store |
| stk_chk_en | input | 1 | Stack-limit checking enabled |
| stk_limit | input | 32 | Lowest permitted stack address |
| rf_raddr | output | 4 | Register file read index |
| rf_rdata | input | 32 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write strobe |
| rf_waddr | output | 4 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| mem_valid | output | 1 | Memory word request |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | 1 = store word, 0 = load word |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid with mem_ready |
| fault | output | 1 | One-cycle stack-limit violation pulse |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: a 16-entry register mask, 32-bit data, 4-byte words and stack-pointer index 13. Those defaults bring the real stack-pointer decode and the full-width limit comparator into play. Bases sit close to the limit, so that the equal-to-limit case, a decrementing push that crosses below it and an incrementing pop that starts below it are all reached. A memory model with an optional alternating ready stall exercises request holding. The loaded-base case is observed through the order of register-file writes.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BASE,
    ST_PREP,
    ST_LAUNCH,
    ST_REQ,
    ST_WB,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/lsm_addr_gen.sv
module lsm_addr_gen #(
  parameter int NREG       = 16,
  parameter int DW         = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic [DW-1:0]   base,
  input  logic [NREG-1:0] sel,
  input  logic            dec,
  output logic [DW-1:0]   lowest,
  output logic [DW-1:0]   new_base,
  output logic            empty
);
  localparam int CW = $clog2(NREG + 1);

  logic [CW-1:0] cnt;
  logic [DW-1:0] span;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NREG; i++) begin
      cnt = cnt + CW'(sel[i]);
    end
  end

  assign span     = DW'(cnt) * DW'(WORD_BYTES);
  assign empty    = (cnt == '0);
  assign lowest   = dec ? (base - span) : base;
  assign new_base = dec ? (base - span) : (base + span);
endmodule

// File: rtl/lsm_pick.sv
module lsm_pick #(
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic [NREG-1:0] rem,
  output logic [IW-1:0]   idx,
  output logic [NREG-1:0] onehot
);
  always_comb begin
    idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (rem[i]) idx = IW'(i);
    end
    onehot      = '0;
    onehot[idx] = |rem;
  end
endmodule

// File: rtl/lsm_limit.sv
module lsm_limit #(
  parameter int NREG   = 16,
  parameter int DW     = 32,
  parameter int SP_IDX = 13,
  localparam int IW    = $clog2(NREG)
) (
  input  logic          en,
  input  logic [IW-1:0] base_idx,
  input  logic          wback,
  input  logic [DW-1:0] lowest,
  input  logic [DW-1:0] limit,
  output logic          viol
);
  logic applies;
  assign applies = en && wback && (base_idx == IW'(SP_IDX));
  assign viol    = applies && (lowest < limit);
endmodule

// File: rtl/ldstm_seq.sv
module ldstm_seq #(
  parameter int NREG       = 16,
  parameter int DW         = 32,
  parameter int WORD_BYTES = 4,
  parameter int SP_IDX     = 13,
  localparam int IW        = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [IW-1:0]   cmd_base_idx,
  input  logic [NREG-1:0] cmd_reg_list,
  input  logic            cmd_dec_before,
  input  logic            cmd_wback,
  input  logic            cmd_load,
  input  logic            stk_chk_en,
  input  logic [DW-1:0]   stk_limit,
  output logic [IW-1:0]   rf_raddr,
  input  logic [DW-1:0]   rf_rdata,
  output logic            rf_we,
  output logic [IW-1:0]   rf_waddr,
  output logic [DW-1:0]   rf_wdata,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic            mem_we,
  output logic [DW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic            fault,
  output logic            done
);
  import lsm_pkg::*;

  seq_state_e      state_q;
  logic [IW-1:0]   base_idx_q;
  logic [NREG-1:0] list_q;
  logic [NREG-1:0] rem_q;
  logic            dec_q;
  logic            wb_q;
  logic            load_q;
  logic [DW-1:0]   addr_q;
  logic [DW-1:0]   newbase_q;
  logic [IW-1:0]   cur_q;
  logic [DW-1:0]   ldbase_q;
  logic            ldbase_hit_q;

  logic [DW-1:0]   ag_lowest;
  logic [DW-1:0]   ag_new_base;
  logic            ag_empty;
  logic            lim_viol;
  logic [IW-1:0]   pick_idx;
  logic [NREG-1:0] pick_onehot;

  // Base value is on rf_rdata while in ST_BASE (rf_raddr holds base index).
  lsm_addr_gen #(.NREG(NREG), .DW(DW), .WORD_BYTES(WORD_BYTES)) u_addr (
    .base     (rf_rdata),
    .sel      (list_q),
    .dec      (dec_q),
    .lowest   (ag_lowest),
    .new_base (ag_new_base),
    .empty    (ag_empty)
  );

  lsm_limit #(.NREG(NREG), .DW(DW), .SP_IDX(SP_IDX)) u_limit (
    .en       (stk_chk_en),
    .base_idx (base_idx_q),
    .wback    (wb_q),
    .lowest   (ag_lowest),
    .limit    (stk_limit),
    .viol     (lim_viol)
  );

  lsm_pick #(.NREG(NREG)) u_pick (
    .rem    (rem_q),
    .idx    (pick_idx),
    .onehot (pick_onehot)
  );

  assign cmd_ready = (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      base_idx_q   <= '0;
      list_q       <= '0;
      rem_q        <= '0;
      dec_q        <= 1'b0;
      wb_q         <= 1'b0;
      load_q       <= 1'b0;
      addr_q       <= '0;
      newbase_q    <= '0;
      cur_q        <= '0;
      ldbase_q     <= '0;
      ldbase_hit_q <= 1'b0;
      rf_raddr     <= '0;
      rf_we        <= 1'b0;
      rf_waddr     <= '0;
      rf_wdata     <= '0;
      mem_valid    <= 1'b0;
      mem_we       <= 1'b0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      fault        <= 1'b0;
      done         <= 1'b0;
    end else begin
      rf_we <= 1'b0;
      fault <= 1'b0;
      done  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            base_idx_q   <= cmd_base_idx;
            list_q       <= cmd_reg_list;
            dec_q        <= cmd_dec_before;
            wb_q         <= cmd_wback;
            load_q       <= cmd_load;
            ldbase_hit_q <= 1'b0;
            rf_raddr     <= cmd_base_idx;
            state_q      <= ST_BASE;
          end
        end
        ST_BASE: begin
          addr_q    <= ag_lowest;
          newbase_q <= ag_new_base;
          rem_q     <= list_q;
          if (lim_viol) begin
            fault   <= 1'b1;
            state_q <= ST_DONE;
          end else if (ag_empty) begin
            state_q <= ST_DONE;
          end else begin
            state_q <= ST_PREP;
          end
        end
        ST_PREP: begin
          rf_raddr <= pick_idx;
          cur_q    <= pick_idx;
          rem_q    <= rem_q & ~pick_onehot;
          state_q  <= ST_LAUNCH;
        end
        ST_LAUNCH: begin
          mem_valid <= 1'b1;
          mem_we    <= !load_q;
          mem_addr  <= addr_q;
          mem_wdata <= load_q ? '0 : rf_rdata;
          state_q   <= ST_REQ;
        end
        ST_REQ: begin
          if (mem_ready) begin
            mem_valid <= 1'b0;
            addr_q    <= addr_q + DW'(WORD_BYTES);
            if (load_q) begin
              if (cur_q == base_idx_q) begin
                ldbase_q     <= mem_rdata;
                ldbase_hit_q <= 1'b1;
              end else begin
                rf_we    <= 1'b1;
                rf_waddr <= cur_q;
                rf_wdata <= mem_rdata;
              end
            end
            state_q <= (rem_q == '0) ? ST_WB : ST_PREP;
          end
        end
        ST_WB: begin
          if (wb_q) begin
            rf_we    <= 1'b1;
            rf_waddr <= base_idx_q;
            rf_wdata <= newbase_q;
          end else if (ldbase_hit_q) begin
            rf_we    <= 1'b1;
            rf_waddr <= base_idx_q;
            rf_wdata <= ldbase_q;
          end
          state_q <= ST_DONE;
        end
        ST_DONE: begin
          done    <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lsm_chk.sv
module lsm_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_ready,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [DW-1:0] mem_addr,
  input logic          rf_we,
  input logic          fault,
  input logic          done
);
  AST_FAULT_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    fault |-> !mem_valid); // R6
  AST_FAULT_NO_REG_WRITE: assert property (@(posedge clk) disable iff (rst)
    fault |-> !rf_we); // R6
  AST_FAULT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fault |=> !fault); // R6
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> mem_valid); // R9
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> ($stable(mem_addr) && $stable(mem_we))); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> !mem_valid); // R11
endmodule

bind ldstm_seq lsm_chk #(.DW(DW)) u_lsm_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_ready (cmd_ready),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .rf_we     (rf_we),
  .fault     (fault),
  .done      (done)
);

// File: tb/ldstm_seq_tb.sv
module ldstm_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_base_idx = '0;
  logic [15:0] cmd_reg_list = '0;
  logic        cmd_dec_before = 1'b0;
  logic        cmd_wback = 1'b0;
  logic        cmd_load = 1'b0;
  logic        stk_chk_en = 1'b0;
  logic [31:0] stk_limit = '0;
  logic [3:0]  rf_raddr;
  logic [31:0] rf_rdata;
  logic        rf_we;
  logic [3:0]  rf_waddr;
  logic [31:0] rf_wdata;
  logic        mem_valid;
  logic        mem_ready;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        fault;
  logic        done;

  always #10 clk = ~clk;

  ldstm_seq dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_base_idx(cmd_base_idx), .cmd_reg_list(cmd_reg_list),
    .cmd_dec_before(cmd_dec_before), .cmd_wback(cmd_wback), .cmd_load(cmd_load),
    .stk_chk_en(stk_chk_en), .stk_limit(stk_limit),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .fault(fault), .done(done)
  );

  logic [31:0] regs [16];
  logic [31:0] mem  [256];
  logic        stall_en = 1'b0;
  logic        tgl = 1'b0;

  assign rf_rdata  = regs[rf_raddr];
  assign mem_rdata = mem[mem_addr[9:2]];
  assign mem_ready = !stall_en || tgl;

  int          n_checks = 0;
  int          n_fail = 0;
  int          cyc = 0;
  int          n_acc, n_wr, done_cnt, fault_cnt;
  logic [31:0] acc_addr [32];
  logic        acc_we   [32];
  logic [31:0] acc_data [32];
  logic [3:0]  wr_idx   [32];
  logic [31:0] wr_data  [32];

  always @(posedge clk) begin
    tgl <= ~tgl;
    cyc <= cyc + 1;
    if (!rst) begin
      if (mem_valid && mem_ready) begin
        acc_addr[n_acc[4:0]] <= mem_addr;
        acc_we[n_acc[4:0]]   <= mem_we;
        acc_data[n_acc[4:0]] <= mem_we ? mem_wdata : mem_rdata;
        if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        n_acc <= n_acc + 1;
      end
      if (rf_we) begin
        wr_idx[n_wr[4:0]]  <= rf_waddr;
        wr_data[n_wr[4:0]] <= rf_wdata;
        regs[rf_waddr]     <= rf_wdata;
        n_wr <= n_wr + 1;
      end
      if (done)  done_cnt  <= done_cnt + 1;
      if (fault) fault_cnt <= fault_cnt + 1;
    end
  end

  always @(posedge clk) begin
    if (cyc == 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks = n_checks + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] b, input logic [15:0] l,
                       input bit dec, input bit wb, input bit ld);
    @(negedge clk);
    n_acc = 0; n_wr = 0; done_cnt = 0; fault_cnt = 0;
    cmd_base_idx = b; cmd_reg_list = l; cmd_dec_before = dec;
    cmd_wback = wb; cmd_load = ld; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 400 && done_cnt == 0; i++) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R11 reset cmd_ready", 32'(cmd_ready), 32'd1);
    chk("R11 reset mem_valid", 32'(mem_valid), 32'd0);
    chk("R11 reset done", 32'(done), 32'd0);
    chk("R6 reset fault", 32'(fault), 32'd0);
  endtask

  task automatic t_store_inc;
    logic [31:0] r0, r3, r5;
    regs[2] = 32'h0000_0100;
    r0 = regs[0]; r3 = regs[3]; r5 = regs[5];
    issue(4'd2, 16'h0029, 1'b0, 1'b1, 1'b0);
    chk("R2 count", 32'(n_acc), 32'd3);
    chk("R1 start addr inc", acc_addr[0], 32'h100);
    chk("R2 addr1", acc_addr[1], 32'h104);
    chk("R2 addr2", acc_addr[2], 32'h108);
    chk("R2 data r0", acc_data[0], r0);
    chk("R2 data r3", acc_data[1], r3);
    chk("R2 data r5", acc_data[2], r5);
    chk("R2 store dir", 32'(acc_we[0]), 32'd1);
    chk("R3 wb inc", regs[2], 32'h10C);
    chk("R11 single done", 32'(done_cnt), 32'd1);
  endtask

  task automatic t_store_dec;
    logic [31:0] r1, r4;
    stk_chk_en = 1'b0;
    regs[13] = 32'h0000_0300;
    r1 = regs[1]; r4 = regs[4];
    issue(4'd13, 16'h0012, 1'b1, 1'b1, 1'b0);
    chk("R1 start addr dec", acc_addr[0], 32'h2F8);
    chk("R2 dec data order", acc_data[0], r1);
    chk("R2 dec data order 2", acc_data[1], r4);
    chk("R3 wb dec", regs[13], 32'h2F8);
  endtask

  task automatic t_load_stall;
    regs[9] = 32'h0000_0180;
    mem[8'h60] = 32'h1111_0001; mem[8'h61] = 32'h2222_0002; mem[8'h62] = 32'h3333_0003;
    stall_en = 1'b1;
    issue(4'd9, 16'h0026, 1'b0, 1'b0, 1'b1);
    stall_en = 1'b0;
    chk("R9 stalled count", 32'(n_acc), 32'd3);
    chk("R2 load r1", regs[1], 32'h1111_0001);
    chk("R2 load r2", regs[2], 32'h2222_0002);
    chk("R2 load r5", regs[5], 32'h3333_0003);
    chk("R4 base untouched", regs[9], 32'h180);
    chk("R4 write count", 32'(n_wr), 32'd3);
    chk("R2 load dir", 32'(acc_we[0]), 32'd0);
  endtask

  task automatic t_load_base;
    regs[3] = 32'h0000_0140;
    mem[8'h50] = 32'hAAAA_0000; mem[8'h51] = 32'hBBBB_0000; mem[8'h52] = 32'hCCCC_0000;
    issue(4'd3, 16'h0089, 1'b0, 1'b0, 1'b1);
    chk("R8 write count", 32'(n_wr), 32'd3);
    chk("R8 last write idx", 32'(wr_idx[2]), 32'd3);
    chk("R8 first write idx", 32'(wr_idx[0]), 32'd0);
    chk("R8 base value", regs[3], 32'hBBBB_0000);
    chk("R8 r7 value", regs[7], 32'hCCCC_0000);
  endtask

  task automatic t_limit_equal;
    stk_chk_en = 1'b1; stk_limit = 32'h200;
    regs[13] = 32'h210;
    issue(4'd13, 16'h001E, 1'b1, 1'b1, 1'b0);
    chk("R6 equal no fault", 32'(fault_cnt), 32'd0);
    chk("R6 equal accesses", 32'(n_acc), 32'd4);
    chk("R1 equal lowest", acc_addr[0], 32'h200);
    chk("R3 equal wb", regs[13], 32'h200);
  endtask

  task automatic t_limit_push_fault;
    stk_chk_en = 1'b1; stk_limit = 32'h200;
    regs[13] = 32'h20C;
    issue(4'd13, 16'h001E, 1'b1, 1'b1, 1'b0);
    chk("R6 fault pulse", 32'(fault_cnt), 32'd1);
    chk("R6 no access", 32'(n_acc), 32'd0);
    chk("R6 no reg write", 32'(n_wr), 32'd0);
    chk("R6 sp kept", regs[13], 32'h20C);
    chk("R11 done after fault", 32'(done_cnt), 32'd1);
  endtask

  task automatic t_limit_pop_fault;
    logic [31:0] r4;
    stk_chk_en = 1'b1; stk_limit = 32'h200;
    regs[13] = 32'h1F8;
    r4 = regs[4];
    issue(4'd13, 16'h0070, 1'b0, 1'b1, 1'b1);
    chk("R7 inc fault", 32'(fault_cnt), 32'd1);
    chk("R7 no access", 32'(n_acc), 32'd0);
    chk("R7 r4 kept", regs[4], r4);
    chk("R7 sp kept", regs[13], 32'h1F8);
  endtask

  task automatic t_limit_scope;
    stk_chk_en = 1'b1; stk_limit = 32'h200;
    regs[12] = 32'h100;
    issue(4'd12, 16'h0003, 1'b0, 1'b1, 1'b0);
    chk("R5 other base no fault", 32'(fault_cnt), 32'd0);
    chk("R5 other base accesses", 32'(n_acc), 32'd2);
    regs[13] = 32'h100;
    issue(4'd13, 16'h0001, 1'b0, 1'b0, 1'b1);
    chk("R5 no wb no fault", 32'(fault_cnt), 32'd0);
    chk("R5 no wb accesses", 32'(n_acc), 32'd1);
    stk_chk_en = 1'b0;
    regs[13] = 32'h100;
    issue(4'd13, 16'h0006, 1'b1, 1'b1, 1'b0);
    chk("R5 disabled no fault", 32'(fault_cnt), 32'd0);
    chk("R5 disabled wb", regs[13], 32'hF8);
  endtask

  task automatic t_empty;
    regs[4] = 32'h0000_0120;
    issue(4'd4, 16'h0000, 1'b0, 1'b1, 1'b0);
    chk("R10 no access", 32'(n_acc), 32'd0);
    chk("R10 no write", 32'(n_wr), 32'd0);
    chk("R10 done", 32'(done_cnt), 32'd1);
    chk("R10 base kept", regs[4], 32'h120);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 32'hC0DE_0000 + 32'(i * 32'h111);
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    n_acc = 0; n_wr = 0; done_cnt = 0; fault_cnt = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_store_inc();
    t_store_dec();
    t_load_stall();
    t_load_base();
    t_limit_equal();
    t_limit_push_fault();
    t_limit_pop_fault();
    t_limit_scope();
    t_empty();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule